// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a single-lane SPI master that a processor drives through a small word-addressed register port. Software chooses the serial clock rate, the SPI mode and the word length in a control register, then writes a word to the data register. That write launches one full-duplex exchange. The outgoing word is shifted out most significant bit first, and the incoming word is collected at the same time. When the last bit has gone, a sticky completion flag in the control register turns on. That flag can also drive an interrupt line. Software reads the received word back from the data register and clears the flag through a separate write-only register. Chip select is handled outside the block by a general-purpose output.

The serial engine is a three-state machine. `ENG_IDLE` holds SCK at its idle level. `ENG_LEAD` is the first half of a bit period, and `ENG_TRAIL` is the second half. The transitions are:
- start: `ENG_IDLE` to `ENG_LEAD`, on an accepted data write while the controller is active.
- leading edge: `ENG_LEAD` to `ENG_TRAIL`, when a half period expires.
- next bit: `ENG_TRAIL` to `ENG_LEAD`, when a half period expires and bits remain.
- finish: `ENG_TRAIL` to `ENG_IDLE`, when a half period expires on the final bit.
- abort: `ENG_LEAD` or `ENG_TRAIL` to `ENG_IDLE`, whenever the controller stops being active.

A divider produces the half-period ticks from the peripheral clock.

Top module: `spim_ctrl`

## Requirements
- R1: The control register's rate field (bits 3:2) sets the SCK half period in peripheral clock cycles. Code 0 gives 4 cycles, code 1 gives 2, code 2 gives 1 and code 3 gives 7, so the full periods are 8, 4, 2 and 14 cycles.
- R2: The width field (bits 7:6) sets the word length. Code 0 selects 8 bits, code 1 selects 16 bits, and codes 2 and 3 select 32 bits. A transfer produces exactly twice that many SCK edges.
- R3: The controller is active only when the on bit (bit 0) is 1 and the hold bit (bit 1) is 0. While it is inactive, data writes start nothing. If it becomes inactive mid-transfer, the transfer stops and the completion flag is not set.
- R4: The polarity bit (bit 4) is the idle level of SCK. With the phase bit (bit 5) at 0, MISO is sampled on the leading edge and MOSI changes on the trailing edge. With the phase bit at 1, MOSI changes on the leading edge and MISO is sampled on the trailing edge. Data moves MSB first.
- R5: A write to address 1 while the controller is active and idle starts a transfer. The completion flag (control bit 10) becomes 1 when the word is done.
- R6: The completion flag stays 1 until a write to address 2 with bit 0 set. A write to address 2 with bit 0 clear leaves the flag unchanged.
- R7: irq_o is 1 exactly when the completion flag is 1 and the interrupt-enable bit (bit 9) is 1.
- R8: Reading address 1 returns the last received word. Bits above the selected width read as zero.
- R9: Control bit 11 reads 1 during a transfer. A data write that arrives during a transfer is ignored.
- R10: During a transfer, control writes update only bits 0 and 1. While idle, bits 9:0 are all written and read back as written, including the stored FIFO-select bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 2 | Word address: 0 control, 1 data, 2 clear |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Completion interrupt |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
Suppose the divider count or the bit counter goes wrong. That shows up on SCK within one half period: either an edge spacing differs from the selected rate, or the number of edges per word is wrong. Suppose instead the sampling or driving edge is wrong for a mode. Then the word captured by the slave model, or the word read back from address 1, differs from the expected value as soon as that transfer completes. Faults in the flag logic are visible on irq_o and on control bits 10 and 11 in the cycle after the cause: a flag that drops on its own, a flag that survives a clear, or a data write that is wrongly accepted during a transfer.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int DATA_W = 32;   // widest word
    localparam int HALF_W = 3;    // half-period counter width
    localparam int BITS_W = 6;    // bit counter width (holds DATA_W)
    localparam int CTRL_W = 10;   // writable control bits

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_DATA = 2'd1;
    localparam logic [1:0] ADDR_CLR  = 2'd2;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_LEAD,
        ENG_TRAIL
    } eng_state_e;

    typedef struct packed {
        logic       irq_en;   // bit 9
        logic       fifo_sel; // bit 8, stored only
        logic [1:0] width;    // bits 7:6
        logic       cpha;     // bit 5
        logic       cpol;     // bit 4
        logic [1:0] rate;     // bits 3:2
        logic       hold;     // bit 1
        logic       on;       // bit 0
    } ctrl_t;

    function automatic logic [HALF_W-1:0] half_cycles(input logic [1:0] rate);
        case (rate)
            2'd0:    return HALF_W'(4);
            2'd1:    return HALF_W'(2);
            2'd2:    return HALF_W'(1);
            default: return HALF_W'(7);
        endcase
    endfunction

    function automatic logic [BITS_W-1:0] word_bits(input logic [1:0] width);
        case (width)
            2'd0:    return BITS_W'(8);
            2'd1:    return BITS_W'(16);
            default: return BITS_W'(DATA_W);
        endcase
    endfunction

endpackage

// File: rtl/spim_clkdiv.sv
module spim_clkdiv #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] half,
    output logic             tick
);

    logic [CNT_W-1:0] cnt_q;

    assign tick = run && (cnt_q == half - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CNT_BELOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < half)); // R1

endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              start,
    input  logic [DATA_W-1:0] start_word,
    input  logic [BITS_W-1:0] nbits,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              tick,
    input  logic              miso_i,
    output logic              busy,
    output logic              sck_o,
    output logic              mosi_o,
    output logic              done_pulse,
    output logic [DATA_W-1:0] rx_word
);

    eng_state_e        state_q, state_d;
    logic [DATA_W-1:0] tx_sh, rx_sh, aligned, rx_in;
    logic [BITS_W-1:0] bits_left;
    logic              mosi_q;

    assign aligned    = start_word << (BITS_W'(DATA_W) - nbits);
    assign rx_in      = {rx_sh[DATA_W-2:0], miso_i};
    assign busy       = (state_q != ENG_IDLE);
    assign sck_o      = cpol ^ (state_q == ENG_TRAIL);
    assign mosi_o     = mosi_q;
    assign done_pulse = (state_q == ENG_TRAIL) && active && tick && (bits_left == BITS_W'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENG_IDLE:  if (start && active) state_d = ENG_LEAD;
            ENG_LEAD:  if (!active) state_d = ENG_IDLE;
                       else if (tick) state_d = ENG_TRAIL;
            ENG_TRAIL: if (!active) state_d = ENG_IDLE;
                       else if (tick) state_d = (bits_left == BITS_W'(1)) ? ENG_IDLE : ENG_LEAD;
            default:   state_d = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ENG_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh     <= '0;
            rx_sh     <= '0;
            bits_left <= '0;
            mosi_q    <= 1'b0;
            rx_word   <= '0;
        end else begin
            unique case (state_q)
                ENG_IDLE: begin
                    if (start && active) begin
                        tx_sh     <= aligned;
                        rx_sh     <= '0;
                        bits_left <= nbits;
                        mosi_q    <= aligned[DATA_W-1];
                    end
                end
                ENG_LEAD: begin
                    if (active && tick) begin
                        if (!cpha) rx_sh  <= rx_in;
                        else       mosi_q <= tx_sh[DATA_W-1];
                    end
                end
                ENG_TRAIL: begin
                    if (active && tick) begin
                        tx_sh     <= tx_sh << 1;
                        bits_left <= bits_left - 1'b1;
                        if (cpha) rx_sh  <= rx_in;
                        else      mosi_q <= tx_sh[DATA_W-2];
                        if (bits_left == BITS_W'(1)) rx_word <= cpha ? rx_in : rx_sh;
                    end
                end
                default: ;
            endcase
        end
    end

    AST_SCK_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && active && tick) |=> (sck_o != $past(sck_o))); // R1
    AST_SCK_STEADY_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && active && !tick) |=> (sck_o == $past(sck_o))); // R1

endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
    import spim_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_o,
    output logic        sck_o,
    output logic        mosi_o,
    input  logic        miso_i
);

    ctrl_t             ctrl_q;
    logic              done_q;
    logic              busy, active, tick, done_pulse, start;
    logic              wr_ctrl, wr_clr;
    logic [DATA_W-1:0] rx_word;

    assign active  = ctrl_q.on && !ctrl_q.hold;
    assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_clr  = bus_wr && (bus_addr == ADDR_CLR) && bus_wdata[0];
    assign start   = bus_wr && (bus_addr == ADDR_DATA) && !busy;
    assign irq_o   = done_q && ctrl_q.irq_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            if (busy) begin
                ctrl_q.on   <= bus_wdata[0];
                ctrl_q.hold <= bus_wdata[1];
            end else begin
                ctrl_q <= bus_wdata[CTRL_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          done_q <= 1'b0;
        else if (done_pulse) done_q <= 1'b1;
        else if (wr_clr)     done_q <= 1'b0;
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_CTRL: bus_rdata = {20'b0, busy, done_q, ctrl_q};
            ADDR_DATA: bus_rdata = rx_word;
            default:   bus_rdata = '0;
        endcase
    end

    spim_clkdiv #(.CNT_W(HALF_W)) div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .half  (half_cycles(ctrl_q.rate)),
        .tick  (tick)
    );

    spim_engine eng_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .start      (start),
        .start_word (bus_wdata),
        .nbits      (word_bits(ctrl_q.width)),
        .cpol       (ctrl_q.cpol),
        .cpha       (ctrl_q.cpha),
        .tick       (tick),
        .miso_i     (miso_i),
        .busy       (busy),
        .sck_o      (sck_o),
        .mosi_o     (mosi_o),
        .done_pulse (done_pulse),
        .rx_word    (rx_word)
    );

    AST_INACTIVE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !busy); // R3
    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && active) |-> done_q); // R5
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !wr_clr) |=> done_q); // R6
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(ctrl_q[CTRL_W-1:2]))); // R10
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sck_o == ctrl_q.cpol)); // R4

endmodule

// File: tb/spim_ctrl_tb_top.sv
module spim_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, sck_o, mosi_o;
    logic        miso = 1'b0;

    int vectors = 0;
    int errors  = 0;

    // slave model state
    logic        s_cpol = 1'b0, s_cpha = 1'b0, xfer_on = 1'b0;
    logic [31:0] s_tx = '0, s_rx = '0;
    longint      last_t = 0;
    bit          have_last = 0;
    int          gap_min = 0, gap_max = 0, edges = 0;

    always #10 clk = ~clk;

    spim_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o),
        .sck_o     (sck_o),
        .mosi_o    (mosi_o),
        .miso_i    (miso)
    );

    always @(sck_o) begin
        if (xfer_on) begin
            int gap;
            if (have_last) begin
                gap = int'(($time - last_t) / 20);
                if (gap < gap_min) gap_min = gap;
                if (gap > gap_max) gap_max = gap;
            end
            last_t    = $time;
            have_last = 1;
            edges++;
            if (sck_o != s_cpol) begin // leading edge
                if (!s_cpha) s_rx <= {s_rx[30:0], mosi_o};
                else begin
                    miso <= s_tx[31];
                    s_tx <= s_tx << 1;
                end
            end else begin // trailing edge
                if (s_cpha) s_rx <= {s_rx[30:0], mosi_o};
                else begin
                    miso <= s_tx[30];
                    s_tx <= s_tx << 1;
                end
            end
        end
    end

    function automatic int exp_half(input logic [1:0] rate);
        case (rate)
            2'd0: return 4;
            2'd1: return 2;
            2'd2: return 1;
            default: return 7;
        endcase
    endfunction

    function automatic int exp_bits(input logic [1:0] w);
        return (w == 2'd0) ? 8 : (w == 2'd1) ? 16 : 32;
    endfunction

    function automatic logic [31:0] low_mask(input int n);
        return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    endfunction

    function automatic logic [31:0] mk_ctrl(input logic on, input logic hold, input logic [1:0] rate,
                                           input logic cpol, input logic cpha, input logic [1:0] w,
                                           input logic fifo, input logic irq_en);
        return {22'b0, irq_en, fifo, w, cpha, cpol, rate, hold, on};
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic xfer_begin(input logic [31:0] ctrl, input logic [31:0] mword, input logic [31:0] sword);
        int n;
        n = exp_bits(ctrl[7:6]);
        bus_write(2'd0, ctrl);
        s_cpol = ctrl[4]; s_cpha = ctrl[5];
        s_tx = sword << (32 - n); s_rx = '0;
        miso = s_tx[31];
        gap_min = 1000; gap_max = 0; edges = 0; have_last = 0;
        xfer_on = 1'b1;
        bus_write(2'd1, mword);
    endtask

    task automatic xfer_end(input logic [31:0] ctrl, input logic [31:0] mword, input logic [31:0] sword);
        logic [31:0] r;
        int n, h, guard;
        n = exp_bits(ctrl[7:6]);
        h = exp_half(ctrl[3:2]);
        guard = 0;
        bus_read(2'd0, r);
        while (!r[10] && guard < 2000) begin
            @(negedge clk);
            bus_read(2'd0, r);
            guard++;
        end
        xfer_on = 1'b0;
        check("R5 done flag after transfer", {31'b0, r[10]}, 32'd1);
        check("R9 busy clear after transfer", {31'b0, r[11]}, 32'd0);
        check("R2 SCK edge count", edges, 2 * n);
        check("R1 min half period", gap_min, h);
        check("R1 max half period", gap_max, h);
        check("R4 word seen by slave", s_rx & low_mask(n), mword & low_mask(n));
        bus_read(2'd1, r);
        check("R8 received word", r, sword & low_mask(n));
        check("R7 irq level", {31'b0, irq_o}, {31'b0, ctrl[9]});
        bus_write(2'd2, 32'd0);
        bus_read(2'd0, r);
        check("R6 flag kept on clear bit0=0", {31'b0, r[10]}, 32'd1);
        bus_write(2'd2, 32'd1);
        bus_read(2'd0, r);
        check("R6 flag cleared", {31'b0, r[10]}, 32'd0);
        check("R7 irq low after clear", {31'b0, irq_o}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [31:0] r, c, mw, sw;
        void'($urandom(32'd7781));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // reset state
        bus_read(2'd0, r);
        check("R3 control after reset", r, 32'd0);
        bus_read(2'd1, r);
        check("R8 data after reset", r, 32'd0);
        check("R4 sck idle after reset", {31'b0, sck_o}, 32'd0);
        check("R7 irq after reset", {31'b0, irq_o}, 32'd0);

        // R10 readback including stored fifo bit
        c = mk_ctrl(1'b0, 1'b0, 2'd3, 1'b1, 1'b0, 2'd1, 1'b1, 1'b1);
        bus_write(2'd0, c);
        bus_read(2'd0, r);
        check("R10 idle control readback", r, c);
        check("R4 sck idles at polarity 1", {31'b0, sck_o}, 32'd1);

        // R3 inactive: on=0, then on=1 with hold=1
        for (int k = 0; k < 2; k++) begin
            c = mk_ctrl(k == 1, k == 1, 2'd2, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1);
            bus_write(2'd0, c);
            edges = 0; xfer_on = 1'b1;
            bus_write(2'd1, 32'hA5);
            repeat (40) @(negedge clk);
            xfer_on = 1'b0;
            bus_read(2'd0, r);
            check("R3 inactive: no busy", {31'b0, r[11]}, 32'd0);
            check("R3 inactive: no done", {31'b0, r[10]}, 32'd0);
            check("R3 inactive: no SCK edges", edges, 0);
        end

        // R9/R10: writes during a transfer
        c = mk_ctrl(1'b1, 1'b0, 2'd2, 1'b0, 1'b1, 2'd2, 1'b0, 1'b1);
        xfer_begin(c, 32'h1234_5678, 32'hCAFE_F00D);
        bus_read(2'd0, r);
        check("R9 busy during transfer", {31'b0, r[11]}, 32'd1);
        bus_write(2'd1, 32'hFFFF_0000);
        bus_write(2'd0, mk_ctrl(1'b1, 1'b0, 2'd2, 1'b0, 1'b1, 2'd0, 1'b1, 1'b1));
        bus_read(2'd0, r);
        check("R10 width kept during transfer", {30'b0, r[7:6]}, 32'd2);
        check("R10 fifo bit kept during transfer", {31'b0, r[8]}, 32'd0);
        xfer_end(c, 32'h1234_5678, 32'hCAFE_F00D);

        // R3 abort by hold bit
        c = mk_ctrl(1'b1, 1'b0, 2'd3, 1'b0, 1'b0, 2'd2, 1'b0, 1'b1);
        xfer_begin(c, 32'h0F0F_0F0F, 32'h1111_2222);
        repeat (10) @(negedge clk);
        bus_write(2'd0, c | 32'h2);
        repeat (3) @(negedge clk);
        xfer_on = 1'b0;
        bus_read(2'd0, r);
        check("R3 abort clears busy", {31'b0, r[11]}, 32'd0);
        check("R3 abort sets no done", {31'b0, r[10]}, 32'd0);
        check("R3 abort leaves sck idle", {31'b0, sck_o}, 32'd0);

        // constrained random transfers
        for (int i = 0; i < 40; i++) begin
            c = mk_ctrl(1'b1, 1'b0, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                        1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), 1'b0,
                        1'($urandom_range(0, 1)));
            mw = $urandom;
            sw = $urandom;
            if (i == 0) begin mw = 32'hFFFF_FFFF; sw = 32'h8000_0001; end
            if (i == 1) begin mw = 32'h0; sw = 32'hFFFF_FFFF; end
            xfer_begin(c, mw, sw);
            xfer_end(c, mw, sw);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule